// File: doc/BRIEF.md
# Fault Interrupt Aggregator with Masking

This block gathers the event and fault indications of a power-management controller and turns them into one active-low, open-drain interrupt request towards a host processor. It takes four groups of sources:
- level-type undervoltage detections, one per rail;
- level-type thermal warnings, one per sensor;
- level-type residual-voltage detections, one per rail;
- single-cycle event pulses.

Each source has a sticky status bit that the host clears by writing one to it over a small register port.

Undervoltage rails and thermal sensors each carry an individual mask bit. One shared two-bit effect code decides what a masked source still does: nothing, latch only, or latch and interrupt. Residual-voltage sources are governed by a second effect code with the same encoding.

The block also watches the power-state machine:
- Detections are latched only in the active and standby states.
- While the controller sits in its initialize state, the interrupt is held asserted.
- Every entry into the initialize state reloads the mask bits and effect codes from their parameterised nonvolatile defaults.

The pin is a register, so it cannot glitch.

Top module: `fault_irq_aggregator`

## Requirements
- R1: After reset all status bits read 0, the mask registers read their default values (mask bits 0, effect register 0x0A, that is both codes 2'b10), and `irq_pull_low` is 0.
- R2: In the active (pwr_state 2) or standby (pwr_state 3) state, a present unmasked source sets its status bit at the clock edge where it is sampled. `irq_pull_low` becomes 1 at the following edge.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: If a source is still present in the cycle its clear is written, the set wins: the bit stays 1 and the interrupt stays asserted.
- R5: `irq_pull_low` returns to 0 one edge after the last interrupt-enabled status bit is cleared, and not before.
- R6: A masked undervoltage rail or thermal sensor follows effect code bits [1:0] of the effect register. The codes are:
  - 00: it sets no bit and raises no interrupt.
  - 01: it sets its bit but raises no interrupt.
  - 10 or 11: it sets its bit and raises the interrupt.

  Unmasked sources are unaffected by the code.
- R7: Residual-voltage sources follow effect code bits [3:2] of the effect register, with the same meaning as in R6 and no per-rail mask.
- R8: In the off (pwr_state 0) and initialize (pwr_state 1) states, no detection or event sets a status bit.
- R9: While pwr_state is 1, `irq_pull_low` is 1 from the edge at which that state is first sampled, whatever the status bits hold.
- R10: At the edge that first samples pwr_state 1 after another state, both mask registers and the effect register are reloaded with their defaults.
- R11: The register map is as follows:

  | Address | Contents |
  |---|---|
  | 0 | undervoltage status |
  | 1 | thermal status |
  | 2 | residual-voltage status |
  | 3 | event status |
  | 4 | undervoltage mask (read/write) |
  | 5 | thermal mask (read/write) |
  | 6 | effect codes, [1:0] undervoltage/thermal and [3:2] residual-voltage (read/write) |
  | 7 | reads 0 |

  Bit i of a group belongs to source i. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Power state: 0 off, 1 initialize, 2 active, 3 standby |
| uv_det | input | N_UV | Undervoltage detection per rail |
| warm_det | input | N_TH | Thermal warning per sensor |
| rv_det | input | N_RV | Residual-voltage detection per rail |
| evt_pulse | input | N_EV | Other event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| irq_pull_low | output | 1 | 1 drives the interrupt pin low, 0 leaves it high-impedance |

## Verification
The assertions check the following on every cycle:
- an enabled status bit always pulls the pin low one edge later;
- the pin is released once nothing holds it;
- a status bit never drops without a matching write of one;
- nothing latches outside the active and standby states;
- residual-voltage code 00 never latches;
- the initialize state both asserts the pin and restores the defaults.

Only the bench scenarios can show the rest:
- the set-wins outcome of a clear against a persisting fault;
- the three distinct behaviours of masked sources under each effect code, with unmasked neighbours untouched;
- the register-map placement.

// File: rtl/fia_pkg.sv
package fia_pkg;

   typedef enum logic [1:0] {
      PS_OFF    = 2'd0,
      PS_INIT   = 2'd1,
      PS_ACTIVE = 2'd2,
      PS_STBY   = 2'd3
   } pwr_state_e;

   localparam int AW = 3;

   localparam logic [AW-1:0] A_STAT_UV = 3'd0;
   localparam logic [AW-1:0] A_STAT_TH = 3'd1;
   localparam logic [AW-1:0] A_STAT_RV = 3'd2;
   localparam logic [AW-1:0] A_STAT_EV = 3'd3;
   localparam logic [AW-1:0] A_MASK_UV = 3'd4;
   localparam logic [AW-1:0] A_MASK_TH = 3'd5;
   localparam logic [AW-1:0] A_EFFECT  = 3'd6;

   // effect code decode: any nonzero code latches, upper bit enables the interrupt
   function automatic logic eff_latches(input logic [1:0] code);
      return code != 2'b00;
   endfunction

   function automatic logic eff_interrupts(input logic [1:0] code);
      return code[1];
   endfunction

endpackage

// File: rtl/fia_policy.sv
module fia_policy
   import fia_pkg::*;
#(
   parameter int N        = 4,
   parameter bit MASKABLE = 1'b1
) (
   input  logic [N-1:0] mask,
   input  logic [1:0]   code,
   output logic [N-1:0] latch_en,
   output logic [N-1:0] irq_en
);

   generate
      if (MASKABLE) begin : g_per_bit
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign latch_en[i] = mask[i] ? eff_latches(code)    : 1'b1;
            assign irq_en[i]   = mask[i] ? eff_interrupts(code) : 1'b1;
         end
      end else begin : g_global
         logic unused_mask;
         assign unused_mask = ^mask;
         assign latch_en = {N{eff_latches(code)}};
         assign irq_en   = {N{eff_interrupts(code)}};
      end
   endgenerate

endmodule

// File: rtl/fia_status_bank.sv
module fia_status_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         latch_ok,
   input  logic [N-1:0] det,
   input  logic [N-1:0] latch_en,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stat
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic set_now;
      assign set_now = latch_ok & det[i] & latch_en[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          stat[i] <= 1'b0;
         else if (set_now)    stat[i] <= 1'b1;   // set beats a same-cycle clear
         else if (clr[i])     stat[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/fia_cfg_regs.sv
module fia_cfg_regs
   import fia_pkg::*;
#(
   parameter int              N_UV        = 6,
   parameter int              N_TH        = 3,
   parameter int              DW          = 8,
   parameter logic [N_UV-1:0] UV_MASK_DEF = '0,
   parameter logic [N_TH-1:0] TH_MASK_DEF = '0,
   parameter logic [1:0]      UV_EFF_DEF  = 2'b10,
   parameter logic [1:0]      RV_EFF_DEF  = 2'b10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reload,
   input  logic            wr,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [N_UV-1:0] mask_uv,
   output logic [N_TH-1:0] mask_th,
   output logic [1:0]      eff_uv,
   output logic [1:0]      eff_rv
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_uv <= UV_MASK_DEF;
         mask_th <= TH_MASK_DEF;
         eff_uv  <= UV_EFF_DEF;
         eff_rv  <= RV_EFF_DEF;
      end else if (reload) begin
         mask_uv <= UV_MASK_DEF;
         mask_th <= TH_MASK_DEF;
         eff_uv  <= UV_EFF_DEF;
         eff_rv  <= RV_EFF_DEF;
      end else if (wr) begin
         case (addr)
            A_MASK_UV: mask_uv <= wdata[N_UV-1:0];
            A_MASK_TH: mask_th <= wdata[N_TH-1:0];
            A_EFFECT: begin
               eff_uv <= wdata[1:0];
               eff_rv <= wdata[3:2];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/fault_irq_aggregator.sv
module fault_irq_aggregator
   import fia_pkg::*;
#(
   parameter int              N_UV        = 6,
   parameter int              N_TH        = 3,
   parameter int              N_RV        = 6,
   parameter int              N_EV        = 4,
   parameter int              DW          = 8,
   parameter logic [N_UV-1:0] UV_MASK_DEF = '0,
   parameter logic [N_TH-1:0] TH_MASK_DEF = '0,
   parameter logic [1:0]      UV_EFF_DEF  = 2'b10,
   parameter logic [1:0]      RV_EFF_DEF  = 2'b10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      pwr_state,
   input  logic [N_UV-1:0] uv_det,
   input  logic [N_TH-1:0] warm_det,
   input  logic [N_RV-1:0] rv_det,
   input  logic [N_EV-1:0] evt_pulse,
   input  logic            reg_wr,
   input  logic [2:0]      reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            irq_pull_low
);

   localparam int MAXG = (N_UV > N_TH) ? ((N_UV > N_RV) ? N_UV : N_RV)
                                       : ((N_TH > N_RV) ? N_TH : N_RV);

   if (MAXG > DW || N_EV > DW || DW < 4) begin : g_bad_width
      $error("fault_irq_aggregator: every source group and the effect field must fit in DW");
   end

   // ---------------- power state tracking ----------------
   logic [1:0] prev_state;
   logic       in_init, init_entry, latch_ok;

   assign in_init    = (pwr_state == PS_INIT);
   assign init_entry = in_init && (prev_state != PS_INIT);
   assign latch_ok   = (pwr_state == PS_ACTIVE) || (pwr_state == PS_STBY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_state <= PS_OFF;
      else        prev_state <= pwr_state;
   end

   // ---------------- configuration ----------------
   logic [N_UV-1:0] mask_uv;
   logic [N_TH-1:0] mask_th;
   logic [1:0]      eff_uv, eff_rv;

   fia_cfg_regs #(
      .N_UV(N_UV), .N_TH(N_TH), .DW(DW),
      .UV_MASK_DEF(UV_MASK_DEF), .TH_MASK_DEF(TH_MASK_DEF),
      .UV_EFF_DEF(UV_EFF_DEF), .RV_EFF_DEF(RV_EFF_DEF)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .reload(init_entry),
      .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .mask_uv(mask_uv), .mask_th(mask_th), .eff_uv(eff_uv), .eff_rv(eff_rv)
   );

   // ---------------- per-source policy ----------------
   logic [N_UV-1:0] len_uv, ien_uv;
   logic [N_TH-1:0] len_th, ien_th;
   logic [N_RV-1:0] len_rv, ien_rv;
   logic [N_EV-1:0] len_ev, ien_ev;

   fia_policy #(.N(N_UV), .MASKABLE(1'b1)) i_pol_uv (
      .mask(mask_uv), .code(eff_uv), .latch_en(len_uv), .irq_en(ien_uv));
   fia_policy #(.N(N_TH), .MASKABLE(1'b1)) i_pol_th (
      .mask(mask_th), .code(eff_uv), .latch_en(len_th), .irq_en(ien_th));
   fia_policy #(.N(N_RV), .MASKABLE(1'b0)) i_pol_rv (
      .mask({N_RV{1'b0}}), .code(eff_rv), .latch_en(len_rv), .irq_en(ien_rv));

   assign len_ev = '1;
   assign ien_ev = '1;

   // ---------------- write-one-to-clear decode ----------------
   logic [N_UV-1:0] clr_uv;
   logic [N_TH-1:0] clr_th;
   logic [N_RV-1:0] clr_rv;
   logic [N_EV-1:0] clr_ev;

   assign clr_uv = (reg_wr && reg_addr == A_STAT_UV) ? reg_wdata[N_UV-1:0] : '0;
   assign clr_th = (reg_wr && reg_addr == A_STAT_TH) ? reg_wdata[N_TH-1:0] : '0;
   assign clr_rv = (reg_wr && reg_addr == A_STAT_RV) ? reg_wdata[N_RV-1:0] : '0;
   assign clr_ev = (reg_wr && reg_addr == A_STAT_EV) ? reg_wdata[N_EV-1:0] : '0;

   // ---------------- status banks ----------------
   logic [N_UV-1:0] stat_uv;
   logic [N_TH-1:0] stat_th;
   logic [N_RV-1:0] stat_rv;
   logic [N_EV-1:0] stat_ev;

   fia_status_bank #(.N(N_UV)) i_st_uv (.clk(clk), .rst_n(rst_n), .latch_ok(latch_ok),
      .det(uv_det), .latch_en(len_uv), .clr(clr_uv), .stat(stat_uv));
   fia_status_bank #(.N(N_TH)) i_st_th (.clk(clk), .rst_n(rst_n), .latch_ok(latch_ok),
      .det(warm_det), .latch_en(len_th), .clr(clr_th), .stat(stat_th));
   fia_status_bank #(.N(N_RV)) i_st_rv (.clk(clk), .rst_n(rst_n), .latch_ok(latch_ok),
      .det(rv_det), .latch_en(len_rv), .clr(clr_rv), .stat(stat_rv));
   fia_status_bank #(.N(N_EV)) i_st_ev (.clk(clk), .rst_n(rst_n), .latch_ok(latch_ok),
      .det(evt_pulse), .latch_en(len_ev), .clr(clr_ev), .stat(stat_ev));

   // ---------------- interrupt pin ----------------
   logic irq_any;
   assign irq_any = |(stat_uv & ien_uv) | |(stat_th & ien_th)
                  | |(stat_rv & ien_rv) | |(stat_ev & ien_ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_pull_low <= 1'b0;
      else        irq_pull_low <= irq_any | in_init;
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_STAT_UV: reg_rdata = DW'(stat_uv);
         A_STAT_TH: reg_rdata = DW'(stat_th);
         A_STAT_RV: reg_rdata = DW'(stat_rv);
         A_STAT_EV: reg_rdata = DW'(stat_ev);
         A_MASK_UV: reg_rdata = DW'(mask_uv);
         A_MASK_TH: reg_rdata = DW'(mask_th);
         A_EFFECT:  reg_rdata = DW'({eff_rv, eff_uv});
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/fia_checker.sv
module fia_checker
   import fia_pkg::*;
#(
   parameter int              N_UV        = 6,
   parameter int              N_TH        = 3,
   parameter int              N_RV        = 6,
   parameter int              N_EV        = 4,
   parameter logic [N_UV-1:0] UV_MASK_DEF = '0,
   parameter logic [N_TH-1:0] TH_MASK_DEF = '0,
   parameter logic [1:0]      UV_EFF_DEF  = 2'b10,
   parameter logic [1:0]      RV_EFF_DEF  = 2'b10
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      pwr_state,
   input logic [1:0]      prev_state,
   input logic            irq_pull_low,
   input logic            irq_any,
   input logic [N_UV-1:0] stat_uv,
   input logic [N_TH-1:0] stat_th,
   input logic [N_RV-1:0] stat_rv,
   input logic [N_EV-1:0] stat_ev,
   input logic [N_UV-1:0] clr_uv,
   input logic [N_TH-1:0] clr_th,
   input logic [N_RV-1:0] clr_rv,
   input logic [N_EV-1:0] clr_ev,
   input logic [N_UV-1:0] mask_uv,
   input logic [N_TH-1:0] mask_th,
   input logic [1:0]      eff_uv,
   input logic [1:0]      eff_rv
);

   localparam int NT = N_UV + N_TH + N_RV + N_EV;
   logic [NT-1:0] all_stat, all_clr;
   assign all_stat = {stat_uv, stat_th, stat_rv, stat_ev};
   assign all_clr  = {clr_uv, clr_th, clr_rv, clr_ev};

   assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any |=> irq_pull_low);

   assert_irq_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_any && pwr_state != PS_INIT) |=> !irq_pull_low);

   assert_no_silent_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(all_stat) & ~$past(all_clr)) & ~all_stat) == '0));

   assert_no_latch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_OFF || pwr_state == PS_INIT) |=> ((all_stat & ~$past(all_stat)) == '0));

   assert_rv_code0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_rv == 2'b00) |=> ((stat_rv & ~$past(stat_rv)) == '0));

   assert_init_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_INIT) |=> irq_pull_low);

   assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_INIT && prev_state != PS_INIT) |=>
      (mask_uv == UV_MASK_DEF && mask_th == TH_MASK_DEF &&
       eff_uv == UV_EFF_DEF && eff_rv == RV_EFF_DEF));

endmodule

bind fault_irq_aggregator fia_checker #(
   .N_UV(N_UV), .N_TH(N_TH), .N_RV(N_RV), .N_EV(N_EV),
   .UV_MASK_DEF(UV_MASK_DEF), .TH_MASK_DEF(TH_MASK_DEF),
   .UV_EFF_DEF(UV_EFF_DEF), .RV_EFF_DEF(RV_EFF_DEF)
) i_fia_checker (
   .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .prev_state(prev_state),
   .irq_pull_low(irq_pull_low), .irq_any(irq_any),
   .stat_uv(stat_uv), .stat_th(stat_th), .stat_rv(stat_rv), .stat_ev(stat_ev),
   .clr_uv(clr_uv), .clr_th(clr_th), .clr_rv(clr_rv), .clr_ev(clr_ev),
   .mask_uv(mask_uv), .mask_th(mask_th), .eff_uv(eff_uv), .eff_rv(eff_rv)
);

// File: tb/test_fault_irq_aggregator.sv
module test_fault_irq_aggregator;

   localparam int N_UV = 6, N_TH = 3, N_RV = 6, N_EV = 4, DW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      pwr_state = 2'd0;
   logic [N_UV-1:0] uv_det = '0;
   logic [N_TH-1:0] warm_det = '0;
   logic [N_RV-1:0] rv_det = '0;
   logic [N_EV-1:0] evt_pulse = '0;
   logic            reg_wr = 1'b0;
   logic [2:0]      reg_addr = '0;
   logic [DW-1:0]   reg_wdata = '0;
   logic [DW-1:0]   reg_rdata;
   logic            irq_pull_low;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fault_irq_aggregator i_fault_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
      .uv_det(uv_det), .warm_det(warm_det), .rv_det(rv_det), .evt_pulse(evt_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_pull_low(irq_pull_low)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, {24'd0, v}, {24'd0, exp});
   endtask

   task automatic t_reset();
      chk("R1 irq", {31'd0, irq_pull_low}, 0);
      chk_reg("R1 uv stat", 3'd0, 8'h00);
      chk_reg("R1 ev stat", 3'd3, 8'h00);
      chk_reg("R1 uv mask", 3'd4, 8'h00);
      chk_reg("R1 th mask", 3'd5, 8'h00);
      chk_reg("R1 effect", 3'd6, 8'h0A);
      chk_reg("R11 addr7", 3'd7, 8'h00);
   endtask

   task automatic t_unmasked();
      pwr_state = 2'd2;
      step();
      uv_det = 6'b000100;
      step();
      uv_det = '0;
      chk_reg("R2 uv latched", 3'd0, 8'h04);
      chk("R2 irq not yet", {31'd0, irq_pull_low}, 0);
      step();
      chk("R2 irq asserted", {31'd0, irq_pull_low}, 1);
      chk_reg("R3 write0 keeps", 3'd0, 8'h04);
      wr(3'd0, 8'h00);
      chk_reg("R3 write0 keeps bit", 3'd0, 8'h04);
      wr(3'd0, 8'h04);
      chk_reg("R3 write1 clears", 3'd0, 8'h00);
      step();
      chk("R5 irq released", {31'd0, irq_pull_low}, 0);
      // standby: thermal warning
      pwr_state = 2'd3;
      warm_det = 3'b010;
      step();
      warm_det = '0;
      chk_reg("R2 warm latched in standby", 3'd1, 8'h02);
      wr(3'd1, 8'h02);
      chk_reg("R3 warm cleared", 3'd1, 8'h00);
      pwr_state = 2'd2;
      step();
   endtask

   task automatic t_persist();
      uv_det = 6'b001000;
      step();
      wr(3'd0, 8'h08);
      chk_reg("R4 set wins", 3'd0, 8'h08);
      chk("R4 irq held", {31'd0, irq_pull_low}, 1);
      uv_det = '0;
      wr(3'd0, 8'h08);
      chk_reg("R4 cleared after fault gone", 3'd0, 8'h00);
      step();
      chk("R4 irq released", {31'd0, irq_pull_low}, 0);
   endtask

   task automatic t_multi_release();
      uv_det = 6'b000001;
      evt_pulse = 4'b0100;
      step();
      uv_det = '0; evt_pulse = '0;
      chk_reg("R11 event status at addr3", 3'd3, 8'h04);
      wr(3'd0, 8'h01);
      step();
      chk("R5 irq held by event", {31'd0, irq_pull_low}, 1);
      wr(3'd3, 8'h04);
      step();
      chk("R5 irq released after last", {31'd0, irq_pull_low}, 0);
   endtask

   task automatic t_mask_effect();
      wr(3'd4, 8'h01);
      chk_reg("R11 uv mask readback", 3'd4, 8'h01);
      // code 00: masked rail silent, unmasked rail still works
      wr(3'd6, 8'h08);
      uv_det = 6'b000001;
      step();
      step();
      uv_det = '0;
      chk_reg("R6 code00 no latch", 3'd0, 8'h00);
      chk("R6 code00 no irq", {31'd0, irq_pull_low}, 0);
      uv_det = 6'b000010;
      step();
      uv_det = '0;
      step();
      chk_reg("R6 unmasked latches", 3'd0, 8'h02);
      chk("R6 unmasked irq", {31'd0, irq_pull_low}, 1);
      wr(3'd0, 8'h02);
      step();
      // code 01: latch without interrupt
      wr(3'd6, 8'h09);
      uv_det = 6'b000001;
      step();
      uv_det = '0;
      step();
      chk_reg("R6 code01 latches", 3'd0, 8'h01);
      chk("R6 code01 no irq", {31'd0, irq_pull_low}, 0);
      wr(3'd0, 8'h01);
      // code 11: latch and interrupt, masked thermal sensor too
      wr(3'd5, 8'h04);
      wr(3'd6, 8'h0B);
      warm_det = 3'b100;
      step();
      warm_det = '0;
      step();
      chk_reg("R6 code11 warm latches", 3'd1, 8'h04);
      chk("R6 code11 irq", {31'd0, irq_pull_low}, 1);
      wr(3'd1, 8'h04);
      step();
      chk("R6 irq released", {31'd0, irq_pull_low}, 0);
   endtask

   task automatic t_rv_codes();
      wr(3'd6, 8'h02);          // rv code 00
      rv_det = 6'b100000;
      step();
      rv_det = '0;
      step();
      chk_reg("R7 code00 no latch", 3'd2, 8'h00);
      chk("R7 code00 no irq", {31'd0, irq_pull_low}, 0);
      wr(3'd6, 8'h06);          // rv code 01
      rv_det = 6'b100000;
      step();
      rv_det = '0;
      step();
      chk_reg("R7 code01 latches", 3'd2, 8'h20);
      chk("R7 code01 no irq", {31'd0, irq_pull_low}, 0);
      wr(3'd2, 8'h20);
      wr(3'd6, 8'h0A);          // rv code 10
      rv_det = 6'b000010;
      step();
      rv_det = '0;
      step();
      chk_reg("R7 code10 latches", 3'd2, 8'h02);
      chk("R7 code10 irq", {31'd0, irq_pull_low}, 1);
      wr(3'd2, 8'h02);
      step();
   endtask

   task automatic t_idle_states();
      pwr_state = 2'd0;
      uv_det = 6'b010000;
      evt_pulse = 4'b0001;
      step();
      chk_reg("R8 off no uv latch", 3'd0, 8'h00);
      chk_reg("R8 off no event latch", 3'd3, 8'h00);
      pwr_state = 2'd1;
      step();
      uv_det = '0; evt_pulse = '0;
      chk_reg("R8 init no latch", 3'd0, 8'h00);
      pwr_state = 2'd2;
      step();
      step();
      chk("R8 irq after idle", {31'd0, irq_pull_low}, 0);
   endtask

   task automatic t_init_entry();
      wr(3'd4, 8'h15);
      wr(3'd5, 8'h03);
      wr(3'd6, 8'h05);
      chk_reg("R11 effect readback", 3'd6, 8'h05);
      pwr_state = 2'd1;
      step();
      chk("R9 irq low in init", {31'd0, irq_pull_low}, 1);
      chk_reg("R10 uv mask reload", 3'd4, 8'h00);
      chk_reg("R10 th mask reload", 3'd5, 8'h00);
      chk_reg("R10 effect reload", 3'd6, 8'h0A);
      step();
      chk("R9 irq stays low", {31'd0, irq_pull_low}, 1);
      pwr_state = 2'd2;
      step();
      chk("R9 irq released after init", {31'd0, irq_pull_low}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unmasked();
      t_persist();
      t_multi_release();
      t_mask_effect();
      t_rv_codes();
      t_idle_states();
      t_init_entry();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule